// File: doc/BRIEF.md
# Trace capture circular buffer

This block records a stream of 32-bit trace words into on-chip storage that it uses as a ring. Words come in on a valid/ready stream. Software controls the block through a small register bus that carries word addresses, a write strobe and a read strobe. A capture session starts when the enable bit in the control register goes from 0 to 1. During the session, words are stored at the write pointer. When the write pointer passes the last entry, it wraps to entry 0 and the Full flag is set, so older words are overwritten.

A session ends in one of three ways:
- A trigger pulse arrives, followed by a programmed number of further words.
- A manual flush is requested with stop-on-flush set.
- Software clears the enable bit.

When capture ends, the block moves its read pointer to the oldest word that survived. Software then drains the buffer one word per read of the data register. Once every stored word has been read, each further read of that register returns all ones.

Word addresses, which are byte offsets divided by four:

| Address | Register |
|---|---|
| 1 | capacity |
| 3 | status |
| 4 | drain data |
| 5 | read pointer |
| 6 | write pointer |
| 7 | post-trigger count |
| 8 | control |
| 10 | mode |
| 193 | flush control |

Top module: `tcb_capture`

## Requirements
- R1: After reset the status register reads 0x4 (bit 2 Ready=1, bit 0 Full=0, bit 1 Triggered=0). `s_ready` is 0, both pointer registers read 0, and the capacity register reads DEPTH.
- R2: Writing 1 to control bit 0 while the block is disabled starts a session. The start clears both pointers, Full and Triggered. Status Ready then reads 0 and `s_ready` is 1. Each accepted word is stored at the write pointer, and the write pointer register advances by one per word.
- R3: When a word is stored in entry DEPTH-1, the write pointer wraps to 0 and Full (status bit 0) is set. When capture stops with Full set, the read pointer register equals the write pointer, and the drain begins with the oldest surviving word.
- R4: A one-cycle pulse on `trig_in` during capture sets Triggered (status bit 1). A word accepted in the same cycle as the pulse counts as before the trigger. After the trigger, exactly N further words are accepted, where N is the value of the post-trigger count register at session start. Then `s_ready` drops and Ready reads 1.
- R5: A trigger pulse while capture is not running, or any pulse after the first one in a session, has no effect: Triggered and the post-trigger word count are unchanged.
- R6: Writing flush control with bit 6 set starts a flush. Bit 6 reads back 1 until the flush completes, which is the first cycle with `s_valid` low, and then reads 0. If bit 12 of that write was also set, capture stops when the flush completes. If bit 12 was clear, capture continues. Bit 12 reads back as written.
- R7: While capture is not running, each read of the drain data register returns the next stored word in oldest-first order and advances the read pointer. Once no stored word remains, every read returns 0xFFFFFFFF. During capture, reads of that register return 0xFFFFFFFF and do not advance the read pointer.
- R8: Writing 0 to control bit 0 during capture ends the session. Ready reads 1, `s_ready` is 0, and the captured words remain available for draining.
- R9: The mode register stores a 2-bit value and reads it back, with 0 meaning circular buffer. Status bit 5 (memory error) always reads 0.
- R10: The post-trigger count register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Trace word is valid |
| s_data | input | 32 | Trace word |
| s_ready | output | 1 | Block accepts a word this cycle |
| trig_in | input | 1 | Single-cycle trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drain side effect) |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The assertions assume the following about the inputs:
- `reg_wr` and `reg_rd` are never high in the same cycle.
- `trig_in` is a single-cycle pulse.
- The control enable bit is set only while the block is disabled, so that a start is an explicit 0-to-1 transition.

The stimulus keeps within these assumptions. Every bus access is a one-cycle task that raises exactly one strobe. Trigger pulses are generated only by a task that holds `trig_in` for one cycle while `s_valid` is low. Each random session clears the enable bit before it sets it again.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int REG_AW = 10;

  localparam logic [REG_AW-1:0] A_SIZE  = 10'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 10'd3;
  localparam logic [REG_AW-1:0] A_DATA  = 10'd4;
  localparam logic [REG_AW-1:0] A_RPTR  = 10'd5;
  localparam logic [REG_AW-1:0] A_WPTR  = 10'd6;
  localparam logic [REG_AW-1:0] A_TRG   = 10'd7;
  localparam logic [REG_AW-1:0] A_CTRL  = 10'd8;
  localparam logic [REG_AW-1:0] A_MODE  = 10'd10;
  localparam logic [REG_AW-1:0] A_FLUSH = 10'd193;

  localparam int FL_REQ_BIT  = 6;
  localparam int FL_STOP_BIT = 12;

  typedef enum logic [1:0] {
    MODE_CIRC   = 2'd0,
    MODE_SWFIFO = 2'd1,
    MODE_HWFIFO = 2'd2
  } buf_mode_e;

  // status word: bit0 full, bit1 triggered, bit2 ready, bit5 memory error
  function automatic logic [31:0] pack_status(input logic full, input logic trig,
                                              input logic rdy);
    logic [31:0] s;
    s    = '0;
    s[0] = full;
    s[1] = trig;
    s[2] = rdy;
    s[5] = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tcb_track.sv
module tcb_track #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        push,
  input  logic        halt,
  input  logic        pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic        full,
  output logic [AW:0] avail
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      full  <= 1'b0;
      avail <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      full  <= 1'b0;
      avail <= '0;
    end else if (halt) begin
      rptr  <= full ? wptr : '0;
      avail <= full ? (AW+1)'(DEPTH) : {1'b0, wptr};
    end else begin
      if (push) begin
        wptr <= ring_next(wptr);
        if (wptr == LAST) full <= 1'b1;
      end
      if (pop && avail != '0) begin
        rptr  <= ring_next(rptr);
        avail <= avail - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcb_seq.sv
module tcb_seq #(
  parameter int TRG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_req,
  input  logic             flush_req,
  input  logic             flush_stop,
  input  logic             trig_in,
  input  logic             push,
  input  logic             s_valid,
  input  logic [TRG_W-1:0] trg_load,
  output logic             cap_en,
  output logic             running,
  output logic             triggered,
  output logic             flush_pend,
  output logic             halt,
  output logic             accept_ok
);
  logic             stop_q;
  logic [TRG_W-1:0] rem_q;
  logic             trig_done;
  logic             flush_done;

  assign running    = cap_en && !stop_q;
  assign trig_done  = triggered && (rem_q == '0);
  assign flush_done = flush_pend && (!s_valid || !running);
  assign halt       = running && (trig_done || (flush_done && flush_stop) || stop_req);
  assign accept_ok  = running && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en    <= 1'b0;
      stop_q    <= 1'b0;
      triggered <= 1'b0;
      rem_q     <= '0;
    end else if (start) begin
      cap_en    <= 1'b1;
      stop_q    <= 1'b0;
      triggered <= 1'b0;
      rem_q     <= trg_load;
    end else begin
      if (stop_req) cap_en <= 1'b0;
      if (halt) stop_q <= 1'b1;
      if (running && trig_in && !triggered) triggered <= 1'b1;
      if (push && triggered && rem_q != '0) rem_q <= rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_pend <= 1'b0;
    else if (flush_req) flush_pend <= 1'b1;
    else if (flush_done) flush_pend <= 1'b0;
  end
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRG_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  output logic              s_ready,
  input  logic              trig_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic [TRG_W-1:0] trg_q;
  buf_mode_e        mode_q;
  logic             flush_stop_q;

  logic cap_en, running, trig_flag, flush_pend, halt_evt, accept_ok;
  logic start_evt, stop_req, flush_req, push_evt, pop_evt;
  logic [AW-1:0] wptr, rptr;
  logic          full_flag;
  logic [AW:0]   avail;
  logic [31:0]   ram_word;

  logic wr_ctrl, wr_flush;
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_flush  = reg_wr && (reg_addr == A_FLUSH);
  assign start_evt = wr_ctrl && reg_wdata[0] && !cap_en;
  assign stop_req  = wr_ctrl && !reg_wdata[0];
  assign flush_req = wr_flush && reg_wdata[FL_REQ_BIT];
  assign push_evt  = s_valid && accept_ok;
  assign pop_evt   = reg_rd && (reg_addr == A_DATA) && !running && (avail != '0);
  assign s_ready   = accept_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q        <= '0;
      mode_q       <= MODE_CIRC;
      flush_stop_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_TRG)  trg_q <= reg_wdata[TRG_W-1:0];
      if (reg_addr == A_MODE) mode_q <= buf_mode_e'(reg_wdata[1:0]);
      if (wr_flush)           flush_stop_q <= reg_wdata[FL_STOP_BIT];
    end
  end

  tcb_seq #(.TRG_W(TRG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .stop_req(stop_req),
    .flush_req(flush_req), .flush_stop(flush_stop_q), .trig_in(trig_in),
    .push(push_evt), .s_valid(s_valid), .trg_load(trg_q),
    .cap_en(cap_en), .running(running), .triggered(trig_flag),
    .flush_pend(flush_pend), .halt(halt_evt), .accept_ok(accept_ok)
  );

  tcb_track #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(start_evt), .push(push_evt),
    .halt(halt_evt), .pop(pop_evt), .wptr(wptr), .rptr(rptr),
    .full(full_flag), .avail(avail)
  );

  tcb_store #(.DEPTH(DEPTH), .DW(32)) u_store (
    .clk(clk), .wr_en(push_evt), .wr_addr(wptr), .wr_data(s_data),
    .rd_addr(rptr), .rd_data(ram_word)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SIZE:  reg_rdata = 32'(DEPTH);
      A_STAT:  reg_rdata = pack_status(full_flag, trig_flag, !running);
      A_DATA:  reg_rdata = (!running && avail != '0) ? ram_word : '1;
      A_RPTR:  reg_rdata = 32'(rptr);
      A_WPTR:  reg_rdata = 32'(wptr);
      A_TRG:   reg_rdata = 32'(trg_q);
      A_CTRL:  reg_rdata = {31'b0, cap_en};
      A_MODE:  reg_rdata = {30'b0, mode_q};
      A_FLUSH: begin
        reg_rdata[FL_REQ_BIT]  = flush_pend;
        reg_rdata[FL_STOP_BIT] = flush_stop_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tcb_capture_chk.sv
module tcb_capture_chk
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              running,
  input logic              trig_flag,
  input logic              halt_evt,
  input logic              push_evt,
  input logic              start_evt,
  input logic              full_flag,
  input logic [AW-1:0]     wptr,
  input logic [AW:0]       avail
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_SREADY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> running); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> (wptr == '0 && !full_flag && !trig_flag)); // R2
  AST_WRAP_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (push_evt && wptr == LAST) |=> full_flag); // R3
  AST_HALT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) halt_evt |=> !running); // R4
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (trig_flag && !start_evt) |=> trig_flag); // R5
  AST_EMPTY_DRAIN_ONES: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_addr == A_DATA && avail == '0) |-> reg_rdata == 32'hFFFF_FFFF); // R7
  AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) avail <= (AW+1)'(DEPTH)); // R7
endmodule

bind tcb_capture tcb_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .running(running),
  .trig_flag(trig_flag), .halt_evt(halt_evt), .push_evt(push_evt),
  .start_evt(start_evt), .full_flag(full_flag), .wptr(wptr), .avail(avail)
);

// File: tb/tcb_capture_bench.sv
module tcb_capture_bench;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        trig_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [31:0] mem_m [D];
  int  wp_m;
  bit  full_m, trg_m, cap_m, stop_m;
  int  rem_m, trg_set;

  always #5 clk = ~clk;

  tcb_capture #(.DEPTH(D)) u_tcb_capture (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .trig_in(trig_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] exp_status();
    return {29'b0, !(cap_m && !stop_m), trg_m, full_m};
  endfunction

  function automatic bit model_accepts();
    return cap_m && !stop_m && !(trg_m && rem_m == 0);
  endfunction

  task automatic settle_model();
    if (cap_m && !stop_m && trg_m && rem_m == 0) stop_m = 1;
  endtask

  task automatic start_session();
    wr(10'd8, 32'd1);
    cap_m = 1; stop_m = 0; trg_m = 0; full_m = 0; wp_m = 0; rem_m = trg_set;
  endtask

  task automatic push(input logic [31:0] d, input string tag);
    bit acc, expa;
    expa = model_accepts();
    @(negedge clk); s_valid = 1'b1; s_data = d; #1 acc = s_ready;
    @(posedge clk); #1 s_valid = 1'b0;
    chk(tag, {31'b0, acc}, {31'b0, expa});
    if (expa) begin
      mem_m[wp_m] = d;
      if (wp_m == D - 1) begin wp_m = 0; full_m = 1; end else wp_m++;
      if (trg_m && rem_m > 0) rem_m--;
    end
    settle_model();
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(posedge clk); #1 trig_in = 1'b0;
    if (cap_m && !stop_m && !trg_m) trg_m = 1;
    settle_model();
  endtask

  task automatic drain_check(input string tag);
    logic [31:0] v;
    int n, idx;
    n   = full_m ? D : wp_m;
    idx = full_m ? wp_m : 0;
    for (int i = 0; i < n; i++) begin
      rd(10'd4, v);
      chk({tag, " drain word"}, v, mem_m[idx]);
      idx = (idx + 1) % D;
    end
    rd(10'd4, v); chk("R7 empty drain ones", v, 32'hFFFF_FFFF);
    rd(10'd4, v); chk("R7 empty drain ones again", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    cap_m = 0; stop_m = 0; trg_m = 0; full_m = 0; wp_m = 0; rem_m = 0; trg_set = 0;
    idle(3); #1 rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(10'd3, v); chk("R1 status", v, 32'h4);
    chk("R1 s_ready", {31'b0, s_ready}, 32'h0);
    rd(10'd1, v); chk("R1 size", v, D);
    rd(10'd5, v); chk("R1 rptr", v, 0);
    rd(10'd6, v); chk("R1 wptr", v, 0);

    // R9 / R10 register readback
    wr(10'd10, 32'h2); rd(10'd10, v); chk("R9 mode readback", v, 32'h2);
    wr(10'd10, 32'h0); rd(10'd10, v); chk("R9 mode circular", v, 32'h0);
    wr(10'd7, 32'h5);  rd(10'd7, v);  chk("R10 trigger count readback", v, 32'h5);

    // R5 trigger while idle is ignored
    pulse_trig(); idle(1);
    rd(10'd3, v); chk("R5 idle trigger ignored", v, 32'h4);

    // R2 / R8 / R7 basic session
    trg_set = 0; wr(10'd7, 0);
    start_session(); idle(1);
    rd(10'd3, v); chk("R2 status running", v, 32'h0);
    chk("R2 s_ready high", {31'b0, s_ready}, 32'h1);
    for (int i = 0; i < 5; i++) push($urandom, "R2 accept");
    rd(10'd6, v); chk("R2 wptr after 5", v, 5);
    rd(10'd4, v); chk("R7 read during capture", v, 32'hFFFF_FFFF);
    wr(10'd8, 0); cap_m = 0; idle(1);
    rd(10'd3, v); chk("R8 status after disable", v, 32'h4);
    chk("R8 s_ready low", {31'b0, s_ready}, 32'h0);
    drain_check("R7");

    // R3 / R4 / R5 wrap then trigger with count 3
    trg_set = 3; wr(10'd7, 3);
    start_session();
    for (int i = 0; i < 20; i++) push($urandom, "R3 accept");
    rd(10'd3, v); chk("R3 full set", v, 32'h1);
    pulse_trig();
    push($urandom, "R4 post-trigger");
    pulse_trig(); // R5 second trigger ignored
    for (int i = 0; i < 4; i++) push($urandom, "R5 post-trigger count");
    idle(2);
    rd(10'd3, v); chk("R4 status stopped", v, exp_status());
    rd(10'd5, v);
    chk("R3 rptr equals wptr", v, wp_m);
    drain_check("R3");
    wr(10'd8, 0); cap_m = 0;

    // R4 trigger count zero
    trg_set = 0; wr(10'd7, 0);
    start_session();
    push(32'hA1, "R4 pre"); push(32'hA2, "R4 pre");
    pulse_trig();
    push(32'hA3, "R4 zero count rejects");
    idle(2);
    rd(10'd3, v); chk("R4 zero count status", v, 32'h6);
    drain_check("R4");
    wr(10'd8, 0); cap_m = 0;

    // R6 flush without and with stop
    start_session();
    push(32'hB1, "R6 pre");
    wr(10'h0C1, 32'h40);
    rd(10'h0C1, v); chk("R6 flush pending", v, 32'h40);
    rd(10'h0C1, v); chk("R6 flush done", v, 32'h0);
    rd(10'd3, v); chk("R6 still running", v, 32'h0);
    push(32'hB2, "R6 accept after flush");
    wr(10'h0C1, 32'h1040); idle(2);
    stop_m = 1;
    rd(10'd3, v); chk("R6 stop on flush status", v, 32'h4);
    chk("R6 s_ready low", {31'b0, s_ready}, 32'h0);
    rd(10'h0C1, v); chk("R6 stop bit readback", v, 32'h1000);
    drain_check("R6");
    wr(10'd8, 0); cap_m = 0;
    wr(10'h0C1, 0);

    // random sessions
    for (int s = 0; s < 6; s++) begin
      int nops;
      trg_set = $urandom % 6; wr(10'd7, trg_set);
      start_session();
      nops = 10 + $urandom % 30;
      for (int k = 0; k < nops; k++) begin
        int r;
        r = $urandom % 8;
        if (r == 0) pulse_trig();
        else if (r == 1) idle(1);
        else push($urandom, "R4 random accept");
      end
      idle(2);
      wr(10'd8, 0); cap_m = 0; idle(1);
      rd(10'd3, v); chk("R8 random status", v, exp_status());
      drain_check("R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule